// File: doc/BRIEF.md
# Address-as-Data Memory Self-Test Sequencer

This block is a hardware self-test engine for a memory reached through a simple request/acknowledge port. After a start pulse it makes three ascending sweeps over the locations from 0 up to a configured last address. The first sweep stores a word derived from each location's own address. The second sweep reads each location and checks it, then overwrites that same location with the bitwise complement of its word before going on to the next address. The third sweep checks the complemented words. Because each location's data depends on its address, a decoder that folds two addresses onto one cell gives a wrong word on read. A write that also disturbs a higher location is caught when the sweep reaches that location.

The address-derived word can tile the address across the whole data width or zero-extend it. It can also be XORed with a key that differs per byte, so each byte lane holds different content. The first mismatch is recorded with its address, the expected and observed words, and the sweep number. A one-cycle done pulse closes the run, and a pass flag reports whether the run was clean. A mapping that only permutes addresses, so that every address still reaches its own private cell, keeps a read/write memory correct. It is deliberately not reported.

Top module: `addrDataBist`

## Requirements
- R1: After synchronous reset the engine is idle: busy, done, passOk, failValid and memReq are all 0.
- R2: The word for address a is built bit by bit. With FILL_REP=1, bit i is a[i mod ADDR_W]; with FILL_REP=0, bit i is a[i] for i < ADDR_W and 0 above. With ENCODE_EN=1 each byte lane k is then XORed with the 8-bit key 8'h5A ^ (k*59 mod 256). The complemented word is the bitwise inverse of this word.
- R3: Sweep one issues exactly LAST_ADDR+1 writes, to addresses 0,1,…,LAST_ADDR in that order, each carrying the word of its address.
- R4: Sweep two visits addresses 0..LAST_ADDR in ascending order. At each address it issues a read and then a write of the complemented word to the same address, before any access to the next address.
- R5: Sweep three issues ascending reads of 0..LAST_ADDR, each compared against the complemented word. A mismatch found there is reported with sweep number 3.
- R6: memReq is high only while busy. While memReq is high and memAck is low, memAddr, memWdata and memWe do not change. Each access completes on the clock edge where memAck is high, and read data is taken in that same cycle.
- R7: The first read mismatch sets failValid and captures failAddr, failExp (expected word), failObs (returned word) and failPass (2 or 3). Later mismatches leave these unchanged.
- R8: done is high for exactly one cycle after the final access. In that cycle and until the next start, passOk is 1 exactly when no mismatch occurred during the run.
- R9: A start pulse while busy is ignored: the run continues unchanged, with no restart and no extra accesses.
- R10: With STOP_ON_FAIL=0 (the default), a mismatch does not shorten the run: all 4*(LAST_ADDR+1) accesses are still made.
- R11: An accepted start clears failValid and passOk in the first busy cycle. Reset during a run returns the engine to idle with its status cleared.
- R12: The run flags a decoder that aliases a lower address onto a higher cell, and a write that also corrupts a higher location. It reports a clean pass when two addresses merely swap cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a test run (sampled when idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| passOk | output | 1 | Last run completed with no mismatch |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Access address |
| memWdata | output | DATA_W | Write data |
| memAck | input | 1 | Access accepted/completed this cycle |
| memRdata | input | DATA_W | Read data, valid with memAck on a read |
| failValid | output | 1 | Sticky: a mismatch has been seen |
| failPass | output | 2 | Sweep number of first mismatch |
| failAddr | output | ADDR_W | Address of first mismatch |
| failExp | output | DATA_W | Expected word at first mismatch |
| failObs | output | DATA_W | Returned word at first mismatch |

## Verification
The hardest situations to reach are the memory faults themselves, because a healthy memory never produces a mismatch. The bench's memory model can swap two addresses, alias one address onto a higher cell, let a write to one address also land at a higher one, or hold one stored bit at zero. The stuck bit is chosen where the true word is 0, so the fault only appears in sweep three. Each fault is set up so that the first failing address, sweep and both data words can be worked out by hand. The model also stretches its acknowledge latency, so the hold-stable rule and a start pulse arriving mid-run are exercised.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR1,
    S_RD2,
    S_WR2,
    S_RD3,
    S_FIN
  } bistStateT;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic       clrStatus;
    logic       addrClr;
    logic       addrInc;
    logic       invSel;
    logic       cmpEn;
    logic       finish;
    logic [1:0] passId;
  } bistStrobeT;

endpackage

// File: rtl/bistPattern.sv
module bistPattern #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter bit FILL_REP  = 1'b1,
  parameter bit ENCODE_EN = 1'b1
) (
  input  logic [ADDR_W-1:0] addrIn,
  output logic [DATA_W-1:0] patOut
);

  localparam int LANES = (DATA_W + 7) / 8;

  logic [DATA_W-1:0] baseWord;
  logic [DATA_W-1:0] laneKey;

  for (genvar i = 0; i < DATA_W; i++) begin : gBit
    localparam int LANE = i / 8;
    localparam logic [7:0] KEYB = 8'h5A ^ 8'((LANE * 59) % 256);
    if (FILL_REP) begin : gRep
      assign baseWord[i] = addrIn[i % ADDR_W];
    end else if (i < ADDR_W) begin : gLow
      assign baseWord[i] = addrIn[i];
    end else begin : gZero
      assign baseWord[i] = 1'b0;
    end
    if (ENCODE_EN && (LANE < LANES)) begin : gKey
      assign laneKey[i] = KEYB[i % 8];
    end else begin : gNoKey
      assign laneKey[i] = 1'b0;
    end
  end

  assign patOut = baseWord ^ laneKey;

endmodule

// File: rtl/bistCtrl.sv
module bistCtrl
  import bist_pkg::*;
#(
  parameter bit STOP_ON_FAIL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       memAck,
  input  logic       addrLast,
  input  logic       mismatch,
  output bistStrobeT stb,
  output logic       memReq,
  output logic       memWe,
  output logic       busy,
  output logic       done
);

  bistStateT state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stb       = '0;
    stateNext = state;
    memReq    = (state == S_WR1) || (state == S_RD2) ||
                (state == S_WR2) || (state == S_RD3);
    memWe     = (state == S_WR1) || (state == S_WR2);
    stb.invSel = (state == S_WR2) || (state == S_RD3);
    stb.cmpEn  = memAck && ((state == S_RD2) || (state == S_RD3));
    case (state)
      S_WR1:          stb.passId = 2'd1;
      S_RD2, S_WR2:   stb.passId = 2'd2;
      S_RD3:          stb.passId = 2'd3;
      default:        stb.passId = 2'd0;
    endcase

    case (state)
      S_IDLE: begin
        if (start) begin
          stb.clrStatus = 1'b1;
          stb.addrClr   = 1'b1;
          stateNext     = S_WR1;
        end
      end
      S_WR1: begin
        if (memAck) begin
          if (addrLast) begin
            stb.addrClr = 1'b1;
            stateNext   = S_RD2;
          end else begin
            stb.addrInc = 1'b1;
          end
        end
      end
      S_RD2: begin
        if (memAck) begin
          if (STOP_ON_FAIL && mismatch) begin
            stb.finish = 1'b1;
            stateNext  = S_FIN;
          end else begin
            stateNext = S_WR2;
          end
        end
      end
      S_WR2: begin
        if (memAck) begin
          if (addrLast) begin
            stb.addrClr = 1'b1;
            stateNext   = S_RD3;
          end else begin
            stb.addrInc = 1'b1;
            stateNext   = S_RD2;
          end
        end
      end
      S_RD3: begin
        if (memAck) begin
          if ((STOP_ON_FAIL && mismatch) || addrLast) begin
            stb.finish = 1'b1;
            stateNext  = S_FIN;
          end else begin
            stb.addrInc = 1'b1;
          end
        end
      end
      S_FIN:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !memReq); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> busy); // R9
  AST_CMP_ON_READ: assert property (@(posedge clk) disable iff (rst)
    stb.cmpEn |-> (memReq && !memWe)); // R4

endmodule

// File: rtl/bistDatapath.sv
module bistDatapath
  import bist_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int LAST_ADDR = 47,
  parameter bit FILL_REP  = 1'b1,
  parameter bit ENCODE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  bistStrobeT        stb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              addrLast,
  output logic              mismatch,
  output logic              failValid,
  output logic [1:0]        failPass,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failObs,
  output logic              passOk
);

  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] patWord;
  logic [DATA_W-1:0] expWord;
  logic              newFail;

  bistPattern #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .FILL_REP (FILL_REP),
    .ENCODE_EN(ENCODE_EN)
  ) uPat (
    .addrIn(addrQ),
    .patOut(patWord)
  );

  always_ff @(posedge clk) begin
    if (rst || stb.addrClr) addrQ <= '0;
    else if (stb.addrInc)   addrQ <= addrQ + 1'b1;
  end

  assign expWord  = stb.invSel ? ~patWord : patWord;
  assign memAddr  = addrQ;
  assign memWdata = expWord;
  assign addrLast = (addrQ == LAST_A);
  assign mismatch = (memRdata != expWord);
  assign newFail  = stb.cmpEn && mismatch;

  always_ff @(posedge clk) begin
    if (rst || stb.clrStatus) begin
      failValid <= 1'b0;
      failPass  <= '0;
      failAddr  <= '0;
      failExp   <= '0;
      failObs   <= '0;
    end else if (newFail && !failValid) begin
      failValid <= 1'b1;
      failPass  <= stb.passId;
      failAddr  <= addrQ;
      failExp   <= expWord;
      failObs   <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stb.clrStatus) passOk <= 1'b0;
    else if (stb.finish)      passOk <= !(failValid || newFail);
  end

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (failValid && !stb.clrStatus) |=> (failValid && $stable(failAddr) && $stable(failObs) && $stable(failPass))); // R7
  AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (stb.cmpEn && mismatch && !failValid && !stb.clrStatus) |=> (failValid && failAddr == $past(memAddr) && failObs == $past(memRdata))); // R7
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    passOk |-> !failValid); // R8
  AST_FAIL_SWEEP: assert property (@(posedge clk) disable iff (rst)
    failValid |-> (failPass == 2'd2 || failPass == 2'd3)); // R5

endmodule

// File: rtl/addrDataBist.sv
module addrDataBist
  import bist_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int DATA_W       = 16,
  parameter int LAST_ADDR    = 47,
  parameter bit FILL_REP     = 1'b1,
  parameter bit ENCODE_EN    = 1'b1,
  parameter bit STOP_ON_FAIL = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              passOk,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              failValid,
  output logic [1:0]        failPass,
  output logic [ADDR_W-1:0] failAddr,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failObs
);

  bistStrobeT stb;
  logic       addrLast;
  logic       mismatch;

  bistCtrl #(
    .STOP_ON_FAIL(STOP_ON_FAIL)
  ) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .memAck  (memAck),
    .addrLast(addrLast),
    .mismatch(mismatch),
    .stb     (stb),
    .memReq  (memReq),
    .memWe   (memWe),
    .busy    (busy),
    .done    (done)
  );

  bistDatapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LAST_ADDR(LAST_ADDR),
    .FILL_REP (FILL_REP),
    .ENCODE_EN(ENCODE_EN)
  ) uDp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .addrLast (addrLast),
    .mismatch (mismatch),
    .failValid(failValid),
    .failPass (failPass),
    .failAddr (failAddr),
    .failExp  (failExp),
    .failObs  (failObs),
    .passOk   (passOk)
  );

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWdata) && $stable(memWe))); // R6

endmodule

// File: tb/sim_addrDataBist.sv
module sim_addrDataBist;

  localparam int AW   = 6;
  localparam int DW   = 16;
  localparam int LAST = 47;
  localparam int N    = LAST + 1;
  localparam bit FREP = 1'b1;
  localparam bit ENC  = 1'b1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, passOk, memReq, memWe, failValid;
  logic [AW-1:0] memAddr, failAddr;
  logic [DW-1:0] memWdata, failExp, failObs;
  logic [1:0] failPass;
  logic memAck = 1'b0;
  logic [DW-1:0] memRdata = '0;

  always #5 clk = ~clk;

  addrDataBist #(
    .ADDR_W(AW), .DATA_W(DW), .LAST_ADDR(LAST),
    .FILL_REP(FREP), .ENCODE_EN(ENC), .STOP_ON_FAIL(1'b0)
  ) u0 (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .passOk(passOk), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata),
    .failValid(failValid), .failPass(failPass), .failAddr(failAddr),
    .failExp(failExp), .failObs(failObs)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // expected word for an address (R2)
  function automatic logic [DW-1:0] pat(int a);
    logic [DW-1:0] w;
    for (int i = 0; i < DW; i++) begin
      logic [7:0] key;
      logic b;
      if (FREP) b = a[i % AW];
      else      b = (i < AW) ? a[i] : 1'b0;
      key = 8'h5A ^ 8'(((i / 8) * 59) % 256);
      w[i] = b ^ (ENC ? key[i % 8] : 1'b0);
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- memory model with fault injection ----------------
  logic [DW-1:0] mem [0:(1<<AW)-1];
  int lat = 1;
  int faultMode = 0;   // 0 none, 1 swap, 2 alias, 3 ghost write, 4 stuck bit
  int fA = 0, fB = 0, stuckBit = 0;
  int lcnt = 0;

  function automatic int physOf(int a);
    if (faultMode == 1 && a == fA) return fB;
    if (faultMode == 1 && a == fB) return fA;
    if (faultMode == 2 && a == fA) return fB;
    return a;
  endfunction

  always @(posedge clk) begin : mdl
    int pa;
    logic [DW-1:0] wv;
    if (rst) begin
      memAck <= 1'b0;
      lcnt   <= 0;
    end else if (memAck) begin
      memAck <= 1'b0;
    end else if (memReq) begin
      if (lcnt < lat - 1) lcnt <= lcnt + 1;
      else begin
        lcnt   <= 0;
        memAck <= 1'b1;
        pa = physOf(int'(memAddr));
        if (memWe) begin
          wv = memWdata;
          if (faultMode == 4 && pa == fA) wv[stuckBit] = 1'b0;
          mem[pa] <= wv;
          if (faultMode == 3 && int'(memAddr) == fA) mem[fB] <= memWdata;
        end else begin
          memRdata <= mem[pa];
        end
      end
    end
  end

  // ---------------- transaction monitor ----------------
  bit monClr = 1'b0;
  int txnCount = 0, seqErr = 0, holdErr = 0, doneCount = 0;
  string firstSeq = "";
  bit holdArm = 1'b0;
  logic [AW-1:0] hAddr;
  logic [DW-1:0] hData;
  logic hWe;

  always @(negedge clk) begin
    if (monClr) begin
      txnCount = 0; seqErr = 0; holdErr = 0; doneCount = 0; holdArm = 1'b0;
      firstSeq = "";
    end else begin
      if (done) doneCount++;
      if (holdArm && memReq && (memAddr !== hAddr || memWdata !== hData || memWe !== hWe))
        holdErr++;
      holdArm = memReq && !memAck;
      hAddr = memAddr; hData = memWdata; hWe = memWe;
      if (memReq && memAck) begin
        bit eWe;
        int eA;
        logic [DW-1:0] eD;
        int k;
        k = txnCount;
        if (k < N) begin
          eWe = 1'b1; eA = k; eD = pat(k);
        end else if (k < 3 * N) begin
          eA = (k - N) / 2;
          eWe = ((k - N) % 2) == 1;
          eD = ~pat(eA);
        end else begin
          eWe = 1'b0; eA = k - 3 * N; eD = '0;
        end
        if (k >= 4 * N || memWe !== eWe || int'(memAddr) != eA || (eWe && memWdata !== eD)) begin
          if (seqErr == 0)
            firstSeq = $sformatf("txn %0d we=%0b addr=%0d data=%0h exp we=%0b addr=%0d data=%0h",
                                 k, memWe, memAddr, memWdata, eWe, eA, eD);
          seqErr++;
        end
        txnCount++;
      end
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  logic rPass, rFailV;
  logic [1:0] rPassNo;
  logic [AW-1:0] rAddr;
  logic [DW-1:0] rExp, rObs;
  bit sawDone;

  task automatic resetDut();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic clearMon();
    @(negedge clk);
    monClr = 1'b1;
    @(negedge clk);
    monClr = 1'b0;
  endtask

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits for done, snapshots results, confirms single-cycle pulse (R8)
  task automatic waitDone(input string tag);
    int n;
    n = 0;
    sawDone = 1'b0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    sawDone = done;
    rPass = passOk; rFailV = failValid; rPassNo = failPass;
    rAddr = failAddr; rExp = failExp; rObs = failObs;
    check(sawDone, {"R8 done seen ", tag}, 64'(sawDone), 64'd1);
    @(negedge clk);
    check(!done, {"R8 done one cycle ", tag}, 64'(done), 64'd0);
  endtask

  task automatic runOnce(input string tag);
    clearMon();
    pulseStart();
    check(busy === 1'b1, {"R11 busy after start ", tag}, 64'(busy), 64'd1);
    check(failValid === 1'b0 && passOk === 1'b0, {"R11 status cleared ", tag},
          64'({failValid, passOk}), 64'd0);
    waitDone(tag);
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    resetDut();
    check(busy === 1'b0, "R1 busy", 64'(busy), 0);
    check(done === 1'b0, "R1 done", 64'(done), 0);
    check(passOk === 1'b0, "R1 passOk", 64'(passOk), 0);
    check(failValid === 1'b0, "R1 failValid", 64'(failValid), 0);
    check(memReq === 1'b0, "R1 memReq idle", 64'(memReq), 0);
  endtask

  task automatic tClean(input int l);
    faultMode = 0; lat = l;
    runOnce("clean");
    if (seqErr != 0) $display("  first sequence error: %s", firstSeq);
    check(seqErr == 0, "R2 R3 R4 R5 access order and data", 64'(seqErr), 0);
    check(txnCount == 4 * N, "R3 R4 R5 access count", 64'(txnCount), 64'(4 * N));
    check(rPass === 1'b1 && rFailV === 1'b0, "R8 clean pass", 64'({rPass, rFailV}), 64'b10);
    check(holdErr == 0, "R6 request held stable", 64'(holdErr), 0);
    check(doneCount == 1, "R8 single done", 64'(doneCount), 1);
    @(negedge clk);
    check(passOk === 1'b1 && busy === 1'b0, "R8 passOk holds after done", 64'({passOk, busy}), 64'b10);
  endtask

  task automatic tStartBusy();
    faultMode = 0; lat = 3;
    clearMon();
    pulseStart();
    repeat (40) @(negedge clk);
    pulseStart();
    repeat (300) @(negedge clk);
    pulseStart();
    waitDone("start-busy");
    check(seqErr == 0, "R9 sequence undisturbed by start", 64'(seqErr), 0);
    check(txnCount == 4 * N, "R9 no extra accesses", 64'(txnCount), 64'(4 * N));
    check(doneCount == 1, "R9 single run", 64'(doneCount), 1);
    check(holdErr == 0, "R6 hold with latency 3", 64'(holdErr), 0);
    check(rPass === 1'b1, "R9 pass after ignored start", 64'(rPass), 1);
  endtask

  task automatic tSwap();
    faultMode = 1; fA = 5; fB = 30; lat = 1;
    runOnce("swap");
    check(rPass === 1'b1 && rFailV === 1'b0, "R12 permutation not flagged",
          64'({rPass, rFailV}), 64'b10);
  endtask

  task automatic tAlias();
    faultMode = 2; fA = 5; fB = 9; lat = 2;
    runOnce("alias");
    check(rFailV === 1'b1 && rPass === 1'b0, "R12 alias flagged", 64'({rFailV, rPass}), 64'b10);
    check(rAddr == AW'(5), "R7 alias first addr", 64'(rAddr), 5);
    check(rPassNo == 2'd2, "R7 alias sweep", 64'(rPassNo), 2);
    check(rExp === pat(5), "R7 alias expected word", 64'(rExp), 64'(pat(5)));
    check(rObs === pat(9), "R7 alias observed word", 64'(rObs), 64'(pat(9)));
    check(txnCount == 4 * N, "R10 run continues after mismatch", 64'(txnCount), 64'(4 * N));
  endtask

  task automatic tGhost();
    faultMode = 3; fA = 3; fB = 20; lat = 1;
    runOnce("ghost");
    check(rFailV === 1'b1 && rPass === 1'b0, "R12 collateral write flagged", 64'({rFailV, rPass}), 64'b10);
    check(rAddr == AW'(20) && rPassNo == 2'd2, "R7 ghost addr/sweep",
          64'({rPassNo, rAddr}), 64'({2'd2, AW'(20)}));
    check(rExp === pat(20) && rObs === ~pat(3), "R4 ghost words",
          64'({rExp, rObs}), 64'({pat(20), ~pat(3)}));
  endtask

  task automatic tStuck();
    logic [DW-1:0] p;
    logic [DW-1:0] obs;
    p = pat(11);
    stuckBit = 0;
    for (int i = DW - 1; i >= 0; i--) if (p[i] == 1'b0) stuckBit = i;
    obs = ~p;
    obs[stuckBit] = 1'b0;
    faultMode = 4; fA = 11; lat = 1;
    runOnce("stuck");
    check(rFailV === 1'b1 && rPassNo == 2'd3, "R5 stuck bit in sweep 3",
          64'({rFailV, rPassNo}), 64'b111);
    check(rAddr == AW'(11), "R5 stuck addr", 64'(rAddr), 11);
    check(rExp === ~p && rObs === obs, "R5 stuck words", 64'({rExp, rObs}), 64'({~p, obs}));
  endtask

  task automatic tResetMid();
    faultMode = 2; fA = 1; fB = 2; lat = 1;
    clearMon();
    pulseStart();
    repeat (200) @(negedge clk);
    check(failValid === 1'b1, "R7 fail seen before reset", 64'(failValid), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0 && memReq === 1'b0, "R11 reset mid-run idle", 64'({busy, memReq}), 0);
    check(failValid === 1'b0 && passOk === 1'b0, "R11 reset clears status",
          64'({failValid, passOk}), 0);
  endtask

  initial begin
    tReset();
    tClean(1);
    tStartBusy();
    tSwap();
    tAlias();
    tGhost();
    tStuck();
    tClean(2);
    tResetMid();
    tClean(1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule